// File: doc/BRIEF.md
# Masked Address Window Decoder with Translation

This block sits on the target side of a bus bridge and decides which of a small set of address windows an incoming request falls into. Each window has a base, a mask, a translation value, a translation enable and a space bit that selects memory or IO. Only the top `DEC_BITS` bits of the 32-bit address take part in the decode. A mask bit of 1 makes that address bit part of the compare. A mask bit of 0 leaves that bit out of the compare, which makes the window larger.

When a request is accepted, the block computes the decode against the register contents of that moment and holds the result. It returns the result after one, two or three wait states, as chosen by `lat_sel`. The result gives the index of the winning window, a one-hot vector and an any-hit flag. It also gives the output address: when translation is enabled for the winner, the masked-in upper bits are replaced by the window's translation value.

Software programs the windows through a simple write port. After reset every window holds its parameter defaults, so the bridge works without any configuration.

Top module: `awd_decoder`

## Requirements
- R1: A window hits when every address bit in the top `DEC_BITS` bits whose effective mask bit is 1 equals the matching bit of the window's base. Bits whose mask bit is 0, and all lower address bits, are ignored.
- R2: A window whose mask is all zeros never hits.
- R3: A window hits only when its space bit matches `req_io`. A space bit of 0 means memory and 1 means IO.
- R4: On a memory window the lowest decoded mask bit is always treated as 0. An all-ones mask therefore takes effect only on IO windows.
- R5: When several windows hit, the lowest-numbered one wins. `hit_vec` is the one-hot vector of the winner, `hit_idx` is its index, and `hit_any` is 1 exactly when some window hit.
- R6: With translation built in, when the winner's translation enable is set, the output's upper bits are `(upper & ~effmask) | (xlat & effmask)`. The lower `ADDR_W-DEC_BITS` bits always pass through unchanged. With no hit, or with the enable clear, the output equals the input address.
- R7: With `TRANS_IMPL` = 0, `out_addr` always equals the accepted address, whatever the enables hold.
- R8: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `dec_valid` then pulses for one cycle, `W` edges after acceptance, where `W` is 1, 2 or 3 for `lat_sel` = 1, 2 or 3, and `lat_sel` = 0 acts as 1. `req_ready` is 0 from acceptance until that pulse.
- R9: On reset each window loads its base, mask, translation value, enable and space bit from parameters. `req_ready` resets to 1 and `dec_valid` resets to 0.
- R10: A register write takes effect on the clock edge where `cfg_we` is 1, and later decodes use the new value. `cfg_field` selects the target: 0 is base, 1 is mask, 2 is translation value, and 3 is control. For control, `cfg_wdata[0]` is the translation enable and `cfg_wdata[1]` is the space bit.
- R11: A decode uses the register values present at its acceptance edge. A write during the wait states does not change that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_win | input | WIN_W | Window number for the write |
| cfg_field | input | 2 | Register field selector |
| cfg_wdata | input | WDATA_W | Write data |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Request address |
| req_io | input | 1 | Request space: 0 memory, 1 IO |
| lat_sel | input | 2 | Wait-state setting |
| req_ready | output | 1 | Decoder idle, can accept a request |
| dec_valid | output | 1 | One-cycle pulse: result valid |
| hit_any | output | 1 | Some window hit |
| hit_vec | output | NUM_WIN | One-hot winning window |
| hit_idx | output | WIN_W | Index of the winning window |
| out_addr | output | ADDR_W | Address after translation |

## Verification
The assertions check on every cycle the handshake and timing rules. Acceptance drops `req_ready`, the valid pulse lasts one cycle, and a busy stretch never exceeds three cycles. The held result stays stable while busy, a delivered hit vector is at most one-hot and agrees with the any-hit flag, and each window holds its defaults when reset is released. The bench sweeps every upper-address value in both spaces across several register configurations and compares the results against an arithmetic model. Only these scenarios can show that the hit rule, priority, unimplemented windows, the memory-mask rule, translation and pass-through are correct, together with the exact wait-state count and isolation from a write made mid-decode.

// File: rtl/awd_pkg.sv
package awd_pkg;

    // Register field selector on the write port.
    typedef enum logic [1:0] {
        FLD_BASE = 2'd0,
        FLD_MASK = 2'd1,
        FLD_XLAT = 2'd2,
        FLD_CTRL = 2'd3
    } cfg_field_e;

    // Position of control bits in the write data word.
    localparam int CTRL_TEN_BIT   = 0;
    localparam int CTRL_SPACE_BIT = 1;

endpackage

// File: rtl/awd_window_regs.sv
module awd_window_regs
    import awd_pkg::*;
#(
    parameter int NUM_WIN  = 6,
    parameter int DEC_BITS = 20,
    parameter int WIN_W    = 3,
    parameter int WDATA_W  = 20,
    parameter logic [NUM_WIN*DEC_BITS-1:0] DEF_BASE  = '0,
    parameter logic [NUM_WIN*DEC_BITS-1:0] DEF_MASK  = '0,
    parameter logic [NUM_WIN*DEC_BITS-1:0] DEF_XLAT  = '0,
    parameter logic [NUM_WIN-1:0]          DEF_TEN   = '0,
    parameter logic [NUM_WIN-1:0]          DEF_SPACE = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [WIN_W-1:0]            cfg_win,
    input  logic [1:0]                  cfg_field,
    input  logic [WDATA_W-1:0]          cfg_wdata,
    output logic [NUM_WIN*DEC_BITS-1:0] base_o,
    output logic [NUM_WIN*DEC_BITS-1:0] mask_o,
    output logic [NUM_WIN*DEC_BITS-1:0] xlat_o,
    output logic [NUM_WIN-1:0]          ten_o,
    output logic [NUM_WIN-1:0]          space_o
);

    typedef struct packed {
        logic [DEC_BITS-1:0] base;
        logic [DEC_BITS-1:0] mask;
        logic [DEC_BITS-1:0] xlat;
        logic                ten;
        logic                space;
    } win_t;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        localparam win_t RST_VAL = '{
            base:  DEF_BASE[w*DEC_BITS +: DEC_BITS],
            mask:  DEF_MASK[w*DEC_BITS +: DEC_BITS],
            xlat:  DEF_XLAT[w*DEC_BITS +: DEC_BITS],
            ten:   DEF_TEN[w],
            space: DEF_SPACE[w]
        };

        win_t win_d, win_q;

        always_comb begin
            win_d = win_q;
            if (cfg_we && (cfg_win == WIN_W'(w))) begin
                case (cfg_field_e'(cfg_field))
                    FLD_BASE: win_d.base = cfg_wdata[DEC_BITS-1:0];
                    FLD_MASK: win_d.mask = cfg_wdata[DEC_BITS-1:0];
                    FLD_XLAT: win_d.xlat = cfg_wdata[DEC_BITS-1:0];
                    FLD_CTRL: begin
                        win_d.ten   = cfg_wdata[CTRL_TEN_BIT];
                        win_d.space = cfg_wdata[CTRL_SPACE_BIT];
                    end
                    default: win_d = win_q;
                endcase
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) win_q <= RST_VAL;
            else        win_q <= win_d;
        end

        assign base_o[w*DEC_BITS +: DEC_BITS] = win_q.base;
        assign mask_o[w*DEC_BITS +: DEC_BITS] = win_q.mask;
        assign xlat_o[w*DEC_BITS +: DEC_BITS] = win_q.xlat;
        assign ten_o[w]   = win_q.ten;
        assign space_o[w] = win_q.space;

        // R9: the first sampled state after reset equals the parameter defaults
        p_defaults_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> (win_q == RST_VAL));
    end

endmodule

// File: rtl/awd_window_match.sv
module awd_window_match #(
    parameter int ADDR_W     = 32,
    parameter int DEC_BITS   = 20,
    parameter bit TRANS_IMPL = 1'b1
) (
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                io_i,
    input  logic [DEC_BITS-1:0] base_i,
    input  logic [DEC_BITS-1:0] mask_i,
    input  logic [DEC_BITS-1:0] xlat_i,
    input  logic                xlat_en_i,
    input  logic                space_i,
    output logic                hit_o,
    output logic [ADDR_W-1:0]   addr_o
);

    localparam int LOW_W = ADDR_W - DEC_BITS;
    localparam logic [DEC_BITS-1:0] DEC_LSB = DEC_BITS'(1);

    logic [DEC_BITS-1:0] upper;
    logic [DEC_BITS-1:0] eff_mask;
    logic [DEC_BITS-1:0] new_upper;

    assign upper    = addr_i[ADDR_W-1 -: DEC_BITS];
    // Memory windows never compare the lowest decoded bit (R4).
    assign eff_mask = space_i ? mask_i : (mask_i & ~DEC_LSB);
    assign hit_o    = (eff_mask != '0) && (space_i == io_i)
                    && (((upper ^ base_i) & eff_mask) == '0);

    if (TRANS_IMPL) begin : g_xlat
        assign new_upper = xlat_en_i ? ((upper & ~eff_mask) | (xlat_i & eff_mask))
                                     : upper;
    end else begin : g_pass
        logic unused_xlat;
        assign unused_xlat = &{1'b0, xlat_i, xlat_en_i};
        assign new_upper   = upper;
    end

    assign addr_o = {new_upper, addr_i[LOW_W-1:0]};

endmodule

// File: rtl/awd_prio_pick.sv
module awd_prio_pick #(
    parameter int NUM_WIN = 6,
    parameter int WIN_W   = 3
) (
    input  logic [NUM_WIN-1:0] hits_i,
    output logic [NUM_WIN-1:0] onehot_o,
    output logic [WIN_W-1:0]   idx_o,
    output logic               any_o
);

    always_comb begin
        onehot_o = '0;
        idx_o    = '0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (hits_i[w]) begin
                onehot_o    = '0;
                onehot_o[w] = 1'b1;
                idx_o       = WIN_W'(w);
            end
        end
    end

    assign any_o = |hits_i;

endmodule

// File: rtl/awd_decoder.sv
module awd_decoder
    import awd_pkg::*;
#(
    parameter int NUM_WIN    = 6,
    parameter int ADDR_W     = 32,
    parameter int DEC_BITS   = 20,
    parameter bit TRANS_IMPL = 1'b1,
    parameter int WIN_W      = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
    parameter int WDATA_W    = (DEC_BITS < 2) ? 2 : DEC_BITS,
    parameter logic [NUM_WIN*DEC_BITS-1:0] DEF_BASE  = '0,
    parameter logic [NUM_WIN*DEC_BITS-1:0] DEF_MASK  = {NUM_WIN{~DEC_BITS'(15)}},
    parameter logic [NUM_WIN*DEC_BITS-1:0] DEF_XLAT  = '0,
    parameter logic [NUM_WIN-1:0]          DEF_TEN   = '0,
    parameter logic [NUM_WIN-1:0]          DEF_SPACE = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [WIN_W-1:0]   cfg_win,
    input  logic [1:0]         cfg_field,
    input  logic [WDATA_W-1:0] cfg_wdata,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_io,
    input  logic [1:0]         lat_sel,
    output logic               req_ready,
    output logic               dec_valid,
    output logic               hit_any,
    output logic [NUM_WIN-1:0] hit_vec,
    output logic [WIN_W-1:0]   hit_idx,
    output logic [ADDR_W-1:0]  out_addr
);

    logic [NUM_WIN*DEC_BITS-1:0] base_w, mask_w, xlat_w;
    logic [NUM_WIN-1:0]          ten_w, space_w;
    logic [NUM_WIN-1:0]          raw_hits;
    logic [ADDR_W-1:0]           xaddr [NUM_WIN];
    logic [NUM_WIN-1:0]          pick_vec;
    logic [WIN_W-1:0]            pick_idx;
    logic                        pick_any;
    logic [ADDR_W-1:0]           sel_addr;

    awd_window_regs #(
        .NUM_WIN(NUM_WIN), .DEC_BITS(DEC_BITS), .WIN_W(WIN_W), .WDATA_W(WDATA_W),
        .DEF_BASE(DEF_BASE), .DEF_MASK(DEF_MASK), .DEF_XLAT(DEF_XLAT),
        .DEF_TEN(DEF_TEN), .DEF_SPACE(DEF_SPACE)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win(cfg_win),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
        .base_o(base_w), .mask_o(mask_w), .xlat_o(xlat_w),
        .ten_o(ten_w), .space_o(space_w)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
        awd_window_match #(
            .ADDR_W(ADDR_W), .DEC_BITS(DEC_BITS), .TRANS_IMPL(TRANS_IMPL)
        ) i_match (
            .addr_i(req_addr), .io_i(req_io),
            .base_i(base_w[w*DEC_BITS +: DEC_BITS]),
            .mask_i(mask_w[w*DEC_BITS +: DEC_BITS]),
            .xlat_i(xlat_w[w*DEC_BITS +: DEC_BITS]),
            .xlat_en_i(ten_w[w]), .space_i(space_w[w]),
            .hit_o(raw_hits[w]), .addr_o(xaddr[w])
        );
    end

    awd_prio_pick #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W)) i_prio (
        .hits_i(raw_hits), .onehot_o(pick_vec), .idx_o(pick_idx), .any_o(pick_any)
    );

    always_comb begin
        sel_addr = req_addr;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (pick_vec[w]) sel_addr = xaddr[w];
        end
    end

    typedef struct packed {
        logic               busy;
        logic [1:0]         left;
        logic               vld;
        logic               any;
        logic [NUM_WIN-1:0] vec;
        logic [WIN_W-1:0]   idx;
        logic [ADDR_W-1:0]  addr;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (!st_q.busy) begin
            if (req_valid) begin
                st_d.busy = 1'b1;
                st_d.left = (lat_sel == 2'd0) ? 2'd0 : (lat_sel - 2'd1);
                st_d.any  = pick_any;
                st_d.vec  = pick_vec;
                st_d.idx  = pick_idx;
                st_d.addr = sel_addr;
            end
        end else if (st_q.left == 2'd0) begin
            st_d.busy = 1'b0;
            st_d.vld  = 1'b1;
        end else begin
            st_d.left = st_q.left - 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_ready = !st_q.busy;
    assign dec_valid = st_q.vld;
    assign hit_any   = st_q.any;
    assign hit_vec   = st_q.vec;
    assign hit_idx   = st_q.idx;
    assign out_addr  = st_q.addr;

    // Checker-only count of consecutive busy cycles.
    logic [2:0] busy_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         busy_run_q <= '0;
        else if (!req_ready) busy_run_q <= busy_run_q + 3'd1;
        else                busy_run_q <= '0;
    end

    // R8: acceptance makes the decoder busy on the next cycle
    p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R8: the result strobe lasts a single cycle
    p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    // R8: no more than three wait states
    p_wait_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run_q <= 3'd3);

    // R5: delivered winner is one-hot and agrees with the any-hit flag
    p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> ($onehot0(hit_vec) && (hit_any == (hit_vec != '0))));

    // R11: the held result is frozen while waiting
    p_snapshot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> ($stable(out_addr) && $stable(hit_vec) && $stable(hit_idx)));

endmodule

// File: tb/test_awd_decoder.sv
`timescale 1ns/1ps
module test_awd_decoder;

    localparam int NW = 4;
    localparam int DB = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_win = '0;
    logic [1:0]  cfg_field = '0;
    logic [3:0]  cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_io = 1'b0;
    logic [1:0]  lat_sel = 2'd1;

    logic        req_ready, dec_valid, hit_any;
    logic [3:0]  hit_vec;
    logic [1:0]  hit_idx;
    logic [31:0] out_addr;
    logic        p_ready, p_valid, p_any;
    logic [3:0]  p_vec;
    logic [1:0]  p_idx;
    logic [31:0] p_addr;

    always #4 clk = ~clk;

    awd_decoder #(
        .NUM_WIN(NW), .ADDR_W(32), .DEC_BITS(DB), .TRANS_IMPL(1'b1),
        .DEF_BASE({4'hA, 4'h0, 4'h4, 4'h8}), .DEF_MASK({4'hE, 4'h0, 4'hC, 4'h8}),
        .DEF_XLAT({4'h2, 4'h0, 4'h0, 4'h0}), .DEF_TEN(4'b1000), .DEF_SPACE(4'b0010)
    ) i_awd_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win(cfg_win),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
        .req_addr(req_addr), .req_io(req_io), .lat_sel(lat_sel),
        .req_ready(req_ready), .dec_valid(dec_valid), .hit_any(hit_any),
        .hit_vec(hit_vec), .hit_idx(hit_idx), .out_addr(out_addr)
    );

    awd_decoder #(
        .NUM_WIN(NW), .ADDR_W(32), .DEC_BITS(DB), .TRANS_IMPL(1'b0),
        .DEF_BASE({4'hA, 4'h0, 4'h4, 4'h8}), .DEF_MASK({4'hE, 4'h0, 4'hC, 4'h8}),
        .DEF_XLAT({4'h2, 4'h0, 4'h0, 4'h0}), .DEF_TEN(4'b1000), .DEF_SPACE(4'b0010)
    ) i_awd_decoder_plain (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win(cfg_win),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
        .req_addr(req_addr), .req_io(req_io), .lat_sel(lat_sel),
        .req_ready(p_ready), .dec_valid(p_valid), .hit_any(p_any),
        .hit_vec(p_vec), .hit_idx(p_idx), .out_addr(p_addr)
    );

    int checks = 0;
    int errors = 0;
    int seed   = 0;
    bit done   = 1'b0;

    logic [3:0] sh_base [NW];
    logic [3:0] sh_mask [NW];
    logic [3:0] sh_ta   [NW];
    logic       sh_ten  [NW];
    logic       sh_space[NW];

    logic       e_any;
    logic [1:0] e_idx;
    logic [3:0] e_vec;
    logic [3:0] e_hi;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Arithmetic reference for R1..R6: descending loop leaves the lowest window.
    function automatic void model(input logic [3:0] hi, input logic io);
        logic [3:0] em;
        e_any = 1'b0; e_idx = '0; e_vec = '0; e_hi = hi;
        for (int w = NW - 1; w >= 0; w--) begin
            em = sh_space[w] ? sh_mask[w] : (sh_mask[w] & 4'hE);
            if (em != 4'h0 && sh_space[w] == io && ((hi ^ sh_base[w]) & em) == 4'h0) begin
                e_any = 1'b1;
                e_idx = 2'(w);
                e_vec = 4'(1 << w);
                e_hi  = sh_ten[w] ? ((hi & ~em) | (sh_ta[w] & em)) : hi;
            end
        end
    endfunction

    // R10 field codes: 0 base, 1 mask, 2 translation, 3 control {space, enable}
    function automatic void shadow(input logic [1:0] w, input logic [1:0] f, input logic [3:0] d);
        case (f)
            2'd0: sh_base[w] = d;
            2'd1: sh_mask[w] = d;
            2'd2: sh_ta[w]   = d;
            default: begin sh_ten[w] = d[0]; sh_space[w] = d[1]; end
        endcase
    endfunction

    task automatic do_write(input logic [1:0] w, input logic [1:0] f, input logic [3:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_win = w; cfg_field = f; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        shadow(w, f, d);
    endtask

    task automatic run_decode(input logic [3:0] hi, input logic io, input logic [1:0] sel,
                              input bit mid, input logic [1:0] mw, input logic [1:0] mf,
                              input logic [3:0] md);
        logic [27:0] lo;
        int n;
        int exp_lat;
        lo = 28'h5A3C961 ^ 28'(seed * 32'h0013579);
        seed++;
        model(hi, io);
        exp_lat = (sel == 2'd0) ? 1 : int'(sel);
        @(negedge clk);
        chk(req_ready == 1'b1, "R8 ready when idle", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_addr = {hi, lo}; req_io = io; lat_sel = sel;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R8 busy after accept", 32'(req_ready), 32'd0);
        if (mid) begin
            cfg_we = 1'b1; cfg_win = mw; cfg_field = mf; cfg_wdata = md;
        end
        n = 0;
        while (!dec_valid && n < 8) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            cfg_we = 1'b0;
        end
        if (mid) shadow(mw, mf, md);
        chk(n == exp_lat, "R8 wait states", 32'(n), 32'(exp_lat));
        chk(hit_any == e_any, "R1 R2 R3 R4 any-hit", 32'(hit_any), 32'(e_any));
        chk(hit_vec == e_vec, "R5 hit vector", 32'(hit_vec), 32'(e_vec));
        if (e_any) chk(hit_idx == e_idx, "R5 winner index", 32'(hit_idx), 32'(e_idx));
        chk(out_addr == {e_hi, lo}, mid ? "R11 R6 address" : "R6 translated address",
            out_addr, {e_hi, lo});
        chk(p_valid && p_addr == {hi, lo}, "R7 pass-through", p_addr, {hi, lo});
        @(posedge clk);
        @(negedge clk);
        chk(dec_valid == 1'b0, "R8 single pulse", 32'(dec_valid), 32'd0);
    endtask

    task automatic sweep(input logic [1:0] sel);
        for (int hi = 0; hi < 16; hi++) begin
            for (int io = 0; io < 2; io++) begin
                run_decode(4'(hi), 1'(io), sel, 1'b0, 2'd0, 2'd0, 4'd0);
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R9 defaults mirrored in the shadow model
        sh_base  = '{4'h8, 4'h4, 4'h0, 4'hA};
        sh_mask  = '{4'h8, 4'hC, 4'h0, 4'hE};
        sh_ta    = '{4'h0, 4'h0, 4'h0, 4'h2};
        sh_ten   = '{1'b0, 1'b0, 1'b0, 1'b1};
        sh_space = '{1'b0, 1'b1, 1'b0, 1'b0};

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R9 reset ready", 32'(req_ready), 32'd1);
        chk(dec_valid == 1'b0, "R9 reset valid", 32'(dec_valid), 32'd0);

        // R9 defaults decoded under every wait-state setting (R8)
        sweep(2'd1);
        sweep(2'd2);
        sweep(2'd3);
        sweep(2'd0);

        // R4: all-ones mask on a memory window loses its lowest bit; R10 writes
        do_write(2'd2, 2'd1, 4'hF);
        do_write(2'd2, 2'd0, 4'h6);
        do_write(2'd2, 2'd2, 4'h3);
        do_write(2'd2, 2'd3, 4'b0001);
        sweep(2'd1);

        // R2: window 0 disabled by a zero mask, window 3 now wins on A/B
        do_write(2'd0, 2'd1, 4'h0);
        sweep(2'd2);

        // R5: window 1 moved to memory overlaps window 2, lower index wins
        do_write(2'd1, 2'd3, 4'b0001);
        do_write(2'd1, 2'd2, 4'hF);
        sweep(2'd3);

        // R3 R4: window 1 back to IO with an all-ones mask
        do_write(2'd1, 2'd1, 4'hF);
        do_write(2'd1, 2'd3, 4'b0011);
        sweep(2'd1);

        // R11: rewrite window 3 base during the wait states of a slow decode
        run_decode(4'hA, 1'b0, 2'd3, 1'b1, 2'd3, 2'd0, 4'h0);
        run_decode(4'hA, 1'b0, 2'd1, 1'b0, 2'd0, 2'd0, 4'h0);
        run_decode(4'h0, 1'b0, 2'd2, 1'b0, 2'd0, 2'd0, 4'h0);

        finish_run();
    end

endmodule